// File: doc/BRIEF.md
# Host-Timed DRAM Strobe and Address Multiplexer

This block sits between a host bus and a group of DRAM banks when the host wants to own every edge of the DRAM cycle. It holds a row address (with a bank number) and a column address in two transparent latches. A single row/column select pin chooses which held address drives the multiplexed DRAM address outputs. The row strobe, column strobe and write strobe inputs are passed through to the DRAM with no clocked delay. The design does not create any timing of its own and does not refresh.

The row strobe goes only to the bank named by the latched bank field. The column strobe is gated by the row/column select pin. While row addresses are selected, the column strobe stays inactive. The host must therefore switch the select pin low before it can pulse CAS. This makes the select pin the interlock that guarantees row-address hold time. Reads, writes and read-modify-write cycles are chosen by the write strobe. Page and nibble bursts are made by keeping RAS low, toggling the CAS input, and reloading the column latch between CAS pulses.

All strobes are active low. The address interface has no flow control: a latch captures whatever is on its bus while its enable is high, and there is no back-pressure.

Top module: `drm_strobe_mux`

## Requirements
- R1: The RAS output of the bank selected by the latched bank field (bank b drives `ras_n_o[b]`) equals `ras_in_n` in the same cycle.
- R2: Every RAS output other than the selected bank's is high, so at most one RAS output is low at any time.
- R3: While `rc_sel_i` is 0 (column selected), `cas_n_o` equals `cas_in_n`.
- R4: While `rc_sel_i` is 1 (row selected), `cas_n_o` is 1 whatever the level of `cas_in_n`.
- R5: `we_n_o` equals `win_n` at all times. A low level gives a write, a high level gives a read, and a high-then-low level within one RAS-low cycle gives a read-modify-write.
- R6: `addr_o` carries the row latch output (zero-extended) when `rc_sel_i` is 1, and the column latch output when `rc_sel_i` is 0.
- R7: While a latch enable (`row_le_i` for row and bank, `col_le_i` for column) is 1, that latch's output follows its bus input in the same cycle.
- R8: While a latch enable is 0, that latch holds the value present at the last rising clock edge at which its enable was 1. Changes on its bus have no effect on the outputs.
- R9: While RAS stays low with the column selected, each CAS input pulse reaches `cas_n_o`, and a column latch reload between pulses appears on `addr_o` before the next CAS falling edge (page/nibble burst).
- R10: During reset, both held latch values clear to zero (bank 0 and address 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that captures the latch hold registers |
| rst_n | input | 1 | Active-low synchronous reset of the held addresses |
| row_bus_i | input | ROW_W | Host row address |
| bank_bus_i | input | BANK_W | Host bank number, latched together with the row |
| col_bus_i | input | COL_W | Host column address |
| row_le_i | input | 1 | Row/bank latch enable (1 = transparent) |
| col_le_i | input | 1 | Column latch enable (1 = transparent) |
| rc_sel_i | input | 1 | 1 selects the row address, 0 selects the column address and enables CAS |
| ras_in_n | input | 1 | Host row strobe |
| cas_in_n | input | 1 | Host column strobe |
| win_n | input | 1 | Host write strobe |
| ras_n_o | output | BANKS | Per-bank DRAM row strobes |
| cas_n_o | output | 1 | DRAM column strobe |
| we_n_o | output | 1 | DRAM write enable |
| addr_o | output | ADDR_W | Multiplexed DRAM address |

## Verification
The block is driven through scripted read, write and read-modify-write cycles in every bank. These cycles show whether RAS steering picks the right bank and whether WE passes through unaltered. Some sequences pulse CAS while row addresses are selected, which separates a gated column strobe from a plain pass-through. Page bursts reload the column latch between CAS pulses, and hold phases change the buses with the enables low. Together these show apart transparent and held latch behaviour. A stretch of random stimulus then mixes every input, with a behavioural model compared on each cycle.

// File: rtl/drm_strobe_pkg.sv
package drm_strobe_pkg;

  // Meaning of the row/column select pin.
  typedef enum logic {
    SEL_COL = 1'b0,
    SEL_ROW = 1'b1
  } addr_sel_e;

  // Wider of two field widths, used to size the shared address bus.
  function automatic int wider(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/drm_addr_latch.sv
// Transparent address latch built from a clocked hold register.
// While the enable is high the live input is forwarded and also captured.
// While it is low, the last captured value is shown.
module drm_addr_latch #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (le_i) begin
      hold_q <= d_i;
    end
  end

  assign q_o = le_i ? d_i : hold_q;

endmodule

// File: rtl/drm_bank_steer.sv
// Routes the host row strobe to one bank. All other banks are held high.
module drm_bank_steer #(
  parameter int BANKS  = 4,
  parameter int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic [BANK_W-1:0] bank_i,
  input  logic              ras_in_n,
  output logic [BANKS-1:0]  ras_n_o
);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign ras_n_o[b] = (bank_i == BANK_W'(b)) ? ras_in_n : 1'b1;
  end

endmodule

// File: rtl/drm_col_gate.sv
// Address multiplexer plus the CAS interlock and the WE pass-through.
module drm_col_gate
  import drm_strobe_pkg::*;
#(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 10,
  parameter int ADDR_W = wider(ROW_W, COL_W)
) (
  input  logic              rc_sel_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              cas_in_n,
  input  logic              win_n,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cas_n_o,
  output logic              we_n_o
);

  addr_sel_e sel;
  assign sel = addr_sel_e'(rc_sel_i);

  always_comb begin
    if (sel == SEL_ROW) begin
      addr_o  = ADDR_W'(row_i);
      cas_n_o = 1'b1;
    end else begin
      addr_o  = ADDR_W'(col_i);
      cas_n_o = cas_in_n;
    end
  end

  assign we_n_o = win_n;

endmodule

// File: rtl/drm_strobe_mux.sv
module drm_strobe_mux
  import drm_strobe_pkg::*;
#(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 10,
  parameter int BANKS  = 4,
  parameter int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
  parameter int ADDR_W = wider(ROW_W, COL_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ROW_W-1:0]  row_bus_i,
  input  logic [BANK_W-1:0] bank_bus_i,
  input  logic [COL_W-1:0]  col_bus_i,
  input  logic              row_le_i,
  input  logic              col_le_i,
  input  logic              rc_sel_i,
  input  logic              ras_in_n,
  input  logic              cas_in_n,
  input  logic              win_n,
  output logic [BANKS-1:0]  ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int RB_W = ROW_W + BANK_W;

  logic [RB_W-1:0]   rb_q;
  logic [ROW_W-1:0]  row_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  col_q;

  // The bank number travels with the row address through one latch.
  drm_addr_latch #(.W(RB_W)) u_row_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .le_i  (row_le_i),
    .d_i   ({bank_bus_i, row_bus_i}),
    .q_o   (rb_q)
  );

  assign row_q  = rb_q[ROW_W-1:0];
  assign bank_q = rb_q[RB_W-1:ROW_W];

  drm_addr_latch #(.W(COL_W)) u_col_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .le_i  (col_le_i),
    .d_i   (col_bus_i),
    .q_o   (col_q)
  );

  drm_bank_steer #(.BANKS(BANKS), .BANK_W(BANK_W)) u_steer (
    .bank_i   (bank_q),
    .ras_in_n (ras_in_n),
    .ras_n_o  (ras_n_o)
  );

  drm_col_gate #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) u_gate (
    .rc_sel_i (rc_sel_i),
    .row_i    (row_q),
    .col_i    (col_q),
    .cas_in_n (cas_in_n),
    .win_n    (win_n),
    .addr_o   (addr_o),
    .cas_n_o  (cas_n_o),
    .we_n_o   (we_n_o)
  );

endmodule

// File: rtl/drm_strobe_mux_chk.sv
module drm_strobe_mux_chk #(
  parameter int BANKS  = 4,
  parameter int BANK_W = 2,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              row_le_i,
  input logic              rc_sel_i,
  input logic              ras_in_n,
  input logic              cas_in_n,
  input logic              win_n,
  input logic [BANK_W-1:0] bank_q,
  input logic [BANKS-1:0]  ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic [ADDR_W-1:0] addr_o
);

  p_ras_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ras_n_o[bank_q] == ras_in_n);

  p_one_ras_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ras_n_o) <= 1);

  p_cas_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rc_sel_i |-> (cas_n_o == cas_in_n));

  p_cas_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rc_sel_i |-> cas_n_o);

  p_we_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we_n_o == win_n);

  // R8: a closed row latch keeps the row address steady on the outputs.
  p_row_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!row_le_i && rc_sel_i && $past(!row_le_i) && $past(rc_sel_i)
     && $past(rst_n)) |-> $stable(addr_o));

endmodule

bind drm_strobe_mux drm_strobe_mux_chk #(
  .BANKS (BANKS),
  .BANK_W(BANK_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .row_le_i (row_le_i),
  .rc_sel_i (rc_sel_i),
  .ras_in_n (ras_in_n),
  .cas_in_n (cas_in_n),
  .win_n    (win_n),
  .bank_q   (bank_q),
  .ras_n_o  (ras_n_o),
  .cas_n_o  (cas_n_o),
  .we_n_o   (we_n_o),
  .addr_o   (addr_o)
);

// File: tb/drm_strobe_mux_tb.sv
module drm_strobe_mux_tb;

  localparam int ROW_W  = 10;
  localparam int COL_W  = 10;
  localparam int BANKS  = 4;
  localparam int BANK_W = 2;
  localparam int ADDR_W = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ROW_W-1:0]  row_bus_i = '0;
  logic [BANK_W-1:0] bank_bus_i = '0;
  logic [COL_W-1:0]  col_bus_i = '0;
  logic              row_le_i = 1'b0;
  logic              col_le_i = 1'b0;
  logic              rc_sel_i = 1'b1;
  logic              ras_in_n = 1'b1;
  logic              cas_in_n = 1'b1;
  logic              win_n = 1'b1;
  logic [BANKS-1:0]  ras_n_o;
  logic              cas_n_o;
  logic              we_n_o;
  logic [ADDR_W-1:0] addr_o;

  always #4 clk = ~clk;  // 125 MHz

  drm_strobe_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .BANKS(BANKS)) u_dut (
    .clk(clk), .rst_n(rst_n), .row_bus_i(row_bus_i), .bank_bus_i(bank_bus_i),
    .col_bus_i(col_bus_i), .row_le_i(row_le_i), .col_le_i(col_le_i),
    .rc_sel_i(rc_sel_i), .ras_in_n(ras_in_n), .cas_in_n(cas_in_n),
    .win_n(win_n), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
    .addr_o(addr_o)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  bit page_phase = 1'b0;

  // Behavioural model state: values kept by closed latches.
  int m_row = 0, m_bank = 0, m_col = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare every cycle at the falling edge.
  always @(negedge clk) begin
    if (!finished) begin
      int row_v, bank_v, col_v;
      if (!rst_n) begin
        m_row = 0; m_bank = 0; m_col = 0;
      end else begin
        if (row_le_i) begin m_row = row_bus_i; m_bank = bank_bus_i; end
        if (col_le_i) m_col = col_bus_i;
      end
      if (rst_n) begin
        row_v  = row_le_i ? int'(row_bus_i)  : m_row;
        bank_v = row_le_i ? int'(bank_bus_i) : m_bank;
        col_v  = col_le_i ? int'(col_bus_i)  : m_col;
        for (int b = 0; b < BANKS; b++) begin
          if (b == bank_v) chk("R1 selected RAS", int'(ras_n_o[b]), int'(ras_in_n));
          else             chk("R2 idle RAS", int'(ras_n_o[b]), 1);
        end
        if (rc_sel_i) chk("R4 CAS blocked", int'(cas_n_o), 1);
        else if (page_phase) chk("R9 page CAS", int'(cas_n_o), int'(cas_in_n));
        else chk("R3 CAS pass", int'(cas_n_o), int'(cas_in_n));
        chk("R5 WE", int'(we_n_o), int'(win_n));
        if (rc_sel_i) begin
          if (row_le_i) chk("R7 row open R6", int'(addr_o), row_v);
          else          chk("R8 row held R6", int'(addr_o), row_v);
        end else begin
          if (page_phase)    chk("R9 page column", int'(addr_o), col_v);
          else if (col_le_i) chk("R7 col open R6", int'(addr_o), col_v);
          else               chk("R8 col held R6", int'(addr_o), col_v);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic access(input int bank, input int row, input int col,
                        input bit wr, input bit rmw);
    row_bus_i = ROW_W'(row); bank_bus_i = BANK_W'(bank); row_le_i = 1'b1;
    col_bus_i = COL_W'(col); col_le_i = 1'b1;
    rc_sel_i = 1'b1; win_n = 1'b1;
    step(1);
    row_le_i = 1'b0; col_le_i = 1'b0;
    row_bus_i = ~row_bus_i; col_bus_i = ~col_bus_i;  // R8: bus noise ignored
    ras_in_n = 1'b0; step(1);
    cas_in_n = 1'b0; step(1);                        // R4: CAS blocked
    cas_in_n = 1'b1; rc_sel_i = 1'b0; step(1);
    cas_in_n = 1'b0; win_n = (wr && !rmw) ? 1'b0 : 1'b1; step(1);
    if (rmw) begin win_n = 1'b0; step(1); end
    cas_in_n = 1'b1; ras_in_n = 1'b1; win_n = 1'b1; rc_sel_i = 1'b1; step(1);
  endtask

  initial begin
    // R10: held latch values clear under reset
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R10 reset row", int'(addr_o), 0);
    chk("R10 reset bank RAS0", int'(ras_n_o), 4'hF);
    ras_in_n = 1'b0; step(1);
    chk("R10 reset bank0 selected", int'(ras_n_o), 4'hE);
    ras_in_n = 1'b1; rc_sel_i = 1'b0; step(1);
    chk("R10 reset column", int'(addr_o), 0);
    rc_sel_i = 1'b1;

    for (int b = 0; b < BANKS; b++) begin
      access(b, 16'h123 + b * 7, 16'h2A5 - b, 1'b0, 1'b0);
      access(b, 16'h3F0 ^ b, 16'h00F + b, 1'b1, 1'b0);
      access(b, b * 99, 16'h155, 1'b1, 1'b1);
    end

    // R9: page burst in bank 2
    row_bus_i = 10'h2C3; bank_bus_i = 2'd2; row_le_i = 1'b1; step(1);
    row_le_i = 1'b0; ras_in_n = 1'b0; step(1);
    rc_sel_i = 1'b0; page_phase = 1'b1;
    for (int k = 0; k < 5; k++) begin
      col_bus_i = COL_W'(k * 37 + 5); col_le_i = 1'b1; step(1);
      col_le_i = 1'b0; col_bus_i = '1; cas_in_n = 1'b0; step(1);
      cas_in_n = 1'b1; step(1);
    end
    page_phase = 1'b0; ras_in_n = 1'b1; rc_sel_i = 1'b1; step(1);

    // Random mix of every input
    for (int i = 0; i < 2000; i++) begin
      row_bus_i = ROW_W'($urandom); bank_bus_i = BANK_W'($urandom);
      col_bus_i = COL_W'($urandom);
      row_le_i = ($urandom % 4) == 0; col_le_i = ($urandom % 4) == 0;
      rc_sel_i = $urandom; ras_in_n = $urandom; cas_in_n = $urandom;
      win_n = $urandom;
      step(1);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule